// File: doc/BRIEF.md
# Indexed Addressing Bus Sequencer

This block drives the memory bus of an 8-bit processor core for the two indexed data addressing modes: page-zero indexed and full-address indexed. The core fetches the opcode and then pulses `start` with the mode, the operation class (read, write, or read-modify-write), the index register value, the address of the first operand byte, the store value, and the modify function. From the next cycle on, the sequencer owns the bus until it raises `done`. Every cycle it drives an address and a read/write direction. It includes the non-productive accesses that such a core makes while it is still computing the effective address.

In page-zero mode, the bus first reads the base address before the index is added. The effective address wraps inside page zero. In full-address mode, the first data access goes to the address whose low byte already has the index added but whose high byte has not yet received the carry. A read that stays inside the page completes on that access. Any other case repeats the access at the corrected address. Read-modify-write operations read the operand, write the unchanged value back, and then write the modified value.

The bus contract is the same as a single-phase core. The address and direction are valid throughout a cycle, and read data is captured at the end of that same cycle.

Top module: `idx_bus_seq`

## Requirements
- R1: Out of reset and whenever idle, `busy` and `done` are 0, `bus_rw` is 1 (read) and `bus_addr` is 0.
- R2: The first sequencer cycle reads `oper_addr` to get the low (or page-zero) base byte. In full-address mode (`mode`=1), the second cycle reads `oper_addr`+1 to get the high base byte.
- R3: In page-zero mode (`mode`=0), the second cycle is a read at {0x00, base}, before the index is applied.
- R4: The page-zero effective address is {0x00, (base + index) mod 256}. No carry ever reaches the high byte.
- R5: In full-address mode, the third cycle reads {high base, (low base + index) mod 256}, with no carry applied to the high byte.
- R6: A read (`op`=0) in full-address mode with no page crossing finishes on that third cycle with `done`=1. This makes it three cycles in total.
- R7: On a page crossing, or for write or read-modify-write operations in full-address mode, a fourth cycle accesses {high base + carry, (low base + index) mod 256}. The high byte wraps at 16 bits.
- R8: A write (`op`=1) drives `st_data` with `bus_rw`=0 exactly once, at the effective address, in the last cycle. It takes 3 cycles in page-zero mode and always 4 cycles in full-address mode.
- R9: A read-modify-write (`op`=2 or 3) reads the effective address, writes the value just read back to it in the next cycle, and writes the modified value to the same address in the cycle after that. `done` is 1 on the final write.
- R10: The modify select `fn` encodes: 0 = increment, 1 = decrement, 2 = shift left (a zero enters bit 0), 3 = shift right (a zero enters bit 7). All results are taken modulo 256.
- R11: A `start` pulse while `busy`=1 is ignored. The running sequence continues unchanged.
- R12: `done` is high for exactly one cycle, during the last bus cycle. The following cycle is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence; accepted only when idle |
| mode | input | 1 | 0 = page-zero indexed, 1 = full-address indexed |
| op | input | 2 | 0 = read, 1 = write, 2/3 = read-modify-write |
| fn | input | 2 | Modify function select (R10) |
| idx | input | 8 | Index register value |
| oper_addr | input | 16 | Address of the first operand byte |
| st_data | input | 8 | Value stored by write operations |
| rd_data | input | 8 | Read data, captured at the end of a read cycle |
| bus_addr | output | 16 | Bus address for the current cycle |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_wdata | output | 8 | Write data, meaningful while `bus_rw`=0 |
| busy | output | 1 | The sequencer owns the bus in this cycle |
| done | output | 1 | Last bus cycle of the sequence |

## Verification
The bus outputs come from registered state alone. The first sequencer cycle is therefore the one that follows the clock edge at which `start` is seen. Each later access appears exactly one edge after the previous one. For each case, the bench builds the expected trace of address, direction and write data from the requirements. It compares one trace entry per cycle at the falling edge, answers reads at that same falling edge, and expects `done` only on the final entry and an idle cycle right after it. The variable-length cases are covered separately. These are the early finish of a read with no page crossing, the fixed length of writes, and the three-access read-modify-write. A repeated `start` placed in the middle of a run must leave the trace intact.

// File: rtl/idx_bus_seq_pkg.sv
package idx_bus_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_BASLO = 3'd1,
        SQ_BASHI = 3'd2,
        SQ_ZPDUM = 3'd3,
        SQ_RAW   = 3'd4,
        SQ_FIX   = 3'd5,
        SQ_WOLD  = 3'd6,
        SQ_WNEW  = 3'd7
    } seq_st_e;

    typedef enum logic [1:0] {
        FN_INC = 2'd0,
        FN_DEC = 2'd1,
        FN_SHL = 2'd2,
        FN_SHR = 2'd3
    } mod_fn_e;

    localparam logic MODE_PAGE0 = 1'b0;
    localparam logic MODE_FULL  = 1'b1;

endpackage

// File: rtl/idx_addr_gen.sv
module idx_addr_gen #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic [DW-1:0]    base_lo,
    input  logic [AW-DW-1:0] base_hi,
    input  logic [DW-1:0]    index,
    output logic             carry,
    output logic [AW-1:0]    page0_ea,
    output logic [AW-1:0]    raw_ea,
    output logic [AW-1:0]    fix_ea
);
    localparam int HW = AW - DW;

    logic [DW:0] sum;

    always_comb begin
        sum      = {1'b0, base_lo} + {1'b0, index};
        carry    = sum[DW];
        page0_ea = {{HW{1'b0}}, sum[DW-1:0]};
        raw_ea   = {base_hi, sum[DW-1:0]};
        fix_ea   = {base_hi + HW'(sum[DW]), sum[DW-1:0]};
    end
endmodule

// File: rtl/idx_modify_unit.sv
module idx_modify_unit #(
    parameter int DW = 8
) (
    input  logic [1:0]    fn,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    import idx_bus_seq_pkg::*;

    always_comb begin
        unique case (mod_fn_e'(fn))
            FN_INC:  dout = din + DW'(1);
            FN_DEC:  dout = din - DW'(1);
            FN_SHL:  dout = {din[DW-2:0], 1'b0};
            default: dout = {1'b0, din[DW-1:1]};
        endcase
    end
endmodule

// File: rtl/idx_bus_seq.sv
module idx_bus_seq #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mode,
    input  logic [1:0]    op,
    input  logic [1:0]    fn,
    input  logic [DW-1:0] idx,
    input  logic [AW-1:0] oper_addr,
    input  logic [DW-1:0] st_data,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rw,
    output logic [DW-1:0] bus_wdata,
    output logic          busy,
    output logic          done
);
    import idx_bus_seq_pkg::*;

    localparam int HW = AW - DW;

    typedef struct packed {
        seq_st_e       st;
        logic          mode;
        logic [1:0]    op;
        logic [1:0]    fn;
        logic [DW-1:0] idx;
        logic [AW-1:0] ptr;
        logic [DW-1:0] lo;
        logic [HW-1:0] hi;
        logic [DW-1:0] val;
        logic [DW-1:0] wd;
    } seq_state_t;

    seq_state_t state_d, state_q;

    logic          carry;
    logic [AW-1:0] page0_ea, raw_ea, fix_ea, final_ea;
    logic [DW-1:0] mod_val;
    logic          is_rmw, is_wr;

    idx_addr_gen #(.AW(AW), .DW(DW)) u_addr (
        .base_lo  (state_q.lo),
        .base_hi  (state_q.hi),
        .index    (state_q.idx),
        .carry    (carry),
        .page0_ea (page0_ea),
        .raw_ea   (raw_ea),
        .fix_ea   (fix_ea)
    );

    idx_modify_unit #(.DW(DW)) u_mod (
        .fn   (state_q.fn),
        .din  (state_q.val),
        .dout (mod_val)
    );

    always_comb begin
        is_rmw   = state_q.op[1];
        is_wr    = !state_q.op[1] && state_q.op[0];
        final_ea = (state_q.mode == MODE_FULL) ? fix_ea : page0_ea;
    end

    always_comb begin
        state_d   = state_q;
        bus_addr  = '0;
        bus_rw    = 1'b1;
        bus_wdata = '0;
        done      = 1'b0;
        unique case (state_q.st)
            SQ_IDLE: begin
                if (start) begin
                    state_d.st   = SQ_BASLO;
                    state_d.mode = mode;
                    state_d.op   = op;
                    state_d.fn   = fn;
                    state_d.idx  = idx;
                    state_d.ptr  = oper_addr;
                    state_d.wd   = st_data;
                end
            end
            SQ_BASLO: begin
                bus_addr   = state_q.ptr;
                state_d.lo = rd_data;
                state_d.st = (state_q.mode == MODE_FULL) ? SQ_BASHI : SQ_ZPDUM;
            end
            SQ_BASHI: begin
                bus_addr   = state_q.ptr + AW'(1);
                state_d.hi = HW'(rd_data);
                state_d.st = SQ_RAW;
            end
            SQ_ZPDUM: begin
                bus_addr   = {{HW{1'b0}}, state_q.lo};
                state_d.st = SQ_RAW;
            end
            SQ_RAW: begin
                if (state_q.mode == MODE_PAGE0) begin
                    bus_addr = page0_ea;
                    if (is_rmw) begin
                        state_d.val = rd_data;
                        state_d.st  = SQ_WOLD;
                    end else begin
                        bus_rw     = !is_wr;
                        bus_wdata  = is_wr ? state_q.wd : '0;
                        done       = 1'b1;
                        state_d.st = SQ_IDLE;
                    end
                end else begin
                    bus_addr = raw_ea;
                    if (!is_rmw && !is_wr && !carry) begin
                        done       = 1'b1;
                        state_d.st = SQ_IDLE;
                    end else begin
                        state_d.st = SQ_FIX;
                    end
                end
            end
            SQ_FIX: begin
                bus_addr = fix_ea;
                if (is_rmw) begin
                    state_d.val = rd_data;
                    state_d.st  = SQ_WOLD;
                end else begin
                    bus_rw     = !is_wr;
                    bus_wdata  = is_wr ? state_q.wd : '0;
                    done       = 1'b1;
                    state_d.st = SQ_IDLE;
                end
            end
            SQ_WOLD: begin
                bus_addr   = final_ea;
                bus_rw     = 1'b0;
                bus_wdata  = state_q.val;
                state_d.st = SQ_WNEW;
            end
            default: begin
                bus_addr   = final_ea;
                bus_rw     = 1'b0;
                bus_wdata  = mod_val;
                done       = 1'b1;
                state_d.st = SQ_IDLE;
            end
        endcase
        busy = (state_q.st != SQ_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= '0;
            state_q.st <= SQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/idx_bus_seq_chk.sv
module idx_bus_seq_chk
    import idx_bus_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          bus_rw,
    input logic [AW-1:0] bus_addr,
    input seq_st_e       st,
    input logic          mode_q
);
    // R12: one-cycle done, then idle
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R12: done only while the bus is owned
    a_r12_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R1: idle bus is a read of address zero
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_rw && bus_addr == '0));

    // R9: a write that is not last is followed by a write to the same address
    a_r9_write_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bus_rw && !done) |=> (!bus_rw && $stable(bus_addr)));

    // R4: page-zero accesses never leave page zero
    a_r4_page0_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PAGE0 && (st == SQ_ZPDUM || st == SQ_RAW))
            |-> (bus_addr[AW-1:DW] == '0));

    // R7: the corrected access keeps the low byte of the uncorrected one
    a_r7_fix_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_FIX) |-> (bus_addr[DW-1:0] == $past(bus_addr[DW-1:0])));

    // R11: a start during a run does not end it
    a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> busy);
endmodule

bind idx_bus_seq idx_bus_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .bus_rw   (bus_rw),
    .bus_addr (bus_addr),
    .st       (state_q.st),
    .mode_q   (state_q.mode)
);

// File: tb/tb_idx_bus_seq.sv
module tb_idx_bus_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic [1:0]  op = '0;
    logic [1:0]  fn = '0;
    logic [7:0]  idx = '0;
    logic [15:0] oper_addr = '0;
    logic [7:0]  st_data = '0;
    logic [7:0]  rd_data = '0;
    logic [15:0] bus_addr;
    logic        bus_rw;
    logic [7:0]  bus_wdata;
    logic        busy;
    logic        done;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idx_bus_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .op(op), .fn(fn),
        .idx(idx), .oper_addr(oper_addr), .st_data(st_data), .rd_data(rd_data),
        .bus_addr(bus_addr), .bus_rw(bus_rw), .bus_wdata(bus_wdata),
        .busy(busy), .done(done)
    );

    // {mode, op, fn, idx, ptr, byte0, byte1, operand, store}
    localparam logic [60:0] VECS [NVEC] = '{
        {1'b0, 2'd0, 2'd0, 8'h05, 16'h8000, 8'h10, 8'h00, 8'h5A, 8'h00}, // R3 R4 page0 read
        {1'b0, 2'd0, 2'd0, 8'h20, 16'h8100, 8'hF0, 8'h00, 8'h11, 8'h00}, // R4 wrap
        {1'b0, 2'd1, 2'd0, 8'h01, 16'h8200, 8'h80, 8'h00, 8'h00, 8'h3C}, // R8 page0 write
        {1'b0, 2'd2, 2'd0, 8'h02, 16'h8300, 8'h40, 8'h00, 8'h17, 8'h00}, // R9 R10 inc
        {1'b1, 2'd0, 2'd0, 8'h05, 16'h8400, 8'h10, 8'h12, 8'h77, 8'h00}, // R5 R6 no cross
        {1'b1, 2'd0, 2'd0, 8'h20, 16'h8500, 8'hF0, 8'h12, 8'h66, 8'h00}, // R7 cross
        {1'b1, 2'd1, 2'd0, 8'h01, 16'h8600, 8'h00, 8'h30, 8'h00, 8'h99}, // R8 no cross
        {1'b1, 2'd1, 2'd0, 8'h01, 16'h8700, 8'hFF, 8'h30, 8'h00, 8'hC3}, // R8 cross
        {1'b1, 2'd2, 2'd1, 8'h04, 16'h8800, 8'h34, 8'h40, 8'h00, 8'h00}, // R10 dec
        {1'b1, 2'd3, 2'd2, 8'h90, 16'h8900, 8'h80, 8'h41, 8'h81, 8'h00}, // R10 shl
        {1'b0, 2'd2, 2'd3, 8'hFF, 16'h8A00, 8'h02, 8'h00, 8'h01, 8'h00}, // R10 shr
        {1'b1, 2'd0, 2'd0, 8'h01, 16'h8B00, 8'hFF, 8'hFF, 8'h42, 8'h00}  // R7 high wrap
    };

    logic [15:0] e_addr [8];
    logic        e_rw   [8];
    logic [7:0]  e_wd   [8];
    int          e_n;
    logic [15:0] e_ea;

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] a, input logic r, input logic [7:0] w);
        e_addr[e_n] = a;
        e_rw[e_n]   = r;
        e_wd[e_n]   = w;
        e_n++;
    endtask

    function automatic logic [7:0] modf(input logic [1:0] f, input logic [7:0] v);
        case (f)
            2'd0:    return v + 8'd1;
            2'd1:    return v - 8'd1;
            2'd2:    return {v[6:0], 1'b0};
            default: return {1'b0, v[7:1]};
        endcase
    endfunction

    task automatic build(input logic [60:0] v);
        logic        m  = v[60];
        logic [1:0]  o  = v[59:58];
        logic [1:0]  f  = v[57:56];
        logic [7:0]  ix = v[55:48];
        logic [15:0] p  = v[47:32];
        logic [7:0]  b0 = v[31:24];
        logic [7:0]  b1 = v[23:16];
        logic [7:0]  ov = v[15:8];
        logic [7:0]  sd = v[7:0];
        logic [8:0]  s  = {1'b0, b0} + {1'b0, ix};
        e_n = 0;
        push(p, 1'b1, 8'h00);                          // R2
        if (!m) begin
            push({8'h00, b0}, 1'b1, 8'h00);            // R3
            e_ea = {8'h00, s[7:0]};                    // R4
        end else begin
            push(p + 16'd1, 1'b1, 8'h00);              // R2
            push({b1, s[7:0]}, 1'b1, 8'h00);           // R5
            e_ea = {b1 + {7'd0, s[8]}, s[7:0]};        // R7
            if (o == 2'd0 && !s[8]) return;            // R6
        end
        if (o == 2'd0)      push(e_ea, 1'b1, 8'h00);
        else if (o == 2'd1) push(e_ea, 1'b0, sd);      // R8
        else begin                                      // R9
            push(e_ea, 1'b1, 8'h00);
            push(e_ea, 1'b0, ov);
            push(e_ea, 1'b0, modf(f, ov));              // R10
        end
    endtask

    task automatic run(input logic [60:0] v, input logic poke);
        build(v);
        @(negedge clk);
        start = 1'b1; mode = v[60]; op = v[59:58]; fn = v[57:56]; idx = v[55:48];
        oper_addr = v[47:32]; st_data = v[7:0];
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < e_n; i++) begin
            if (poke && i == 1) begin
                start = 1'b1; mode = ~v[60]; oper_addr = 16'h1234; st_data = 8'hEE;
            end
            if (poke && i == 2) start = 1'b0;
            check(bus_addr == e_addr[i], poke ? "R11 addr" : "R2-trace addr", 32'(bus_addr), 32'(e_addr[i]));
            check(bus_rw == e_rw[i], "R8/R9 rw", 32'(bus_rw), 32'(e_rw[i]));
            if (!e_rw[i]) check(bus_wdata == e_wd[i], "R9/R10 wdata", 32'(bus_wdata), 32'(e_wd[i]));
            check(done == (i == e_n - 1), "R12 done position", 32'(done), 32'(i == e_n - 1));
            check(busy, "R12 busy in run", 32'(busy), 32'd1);
            if (bus_addr == v[47:32])              rd_data = v[31:24];
            else if (bus_addr == v[47:32] + 16'd1) rd_data = v[23:16];
            else if (bus_addr == e_ea)             rd_data = v[15:8];
            else                                   rd_data = 8'hA5;
            @(negedge clk);
        end
        start = 1'b0;
        check(!busy && !done, "R12 idle after done", {busy, done}, 32'd0);
        check(bus_rw && bus_addr == 16'h0, "R1 idle bus", 32'(bus_addr), 32'd0);
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == 100000) begin
            failures = failures + 1;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !done, "R1 reset flags", {busy, done}, 32'd0);
        check(bus_rw && bus_addr == 16'h0, "R1 reset bus", 32'(bus_addr), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < NVEC; k++) run(VECS[k], 1'b0);
        // R11 start during a run is ignored
        run(VECS[9], 1'b1);
        run(VECS[5], 1'b1);
        // R6 boundary: exact fit, lo + idx == 0xFF, no crossing
        run({1'b1, 2'd0, 2'd0, 8'h0F, 16'h8C00, 8'hF0, 8'h20, 8'h3D, 8'h00}, 1'b0);
        // R4 page-zero with idx crossing 0xFF and increment wrap
        run({1'b0, 2'd2, 2'd0, 8'h01, 16'h8D00, 8'hFF, 8'h00, 8'hFF, 8'h00}, 1'b0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule